// File: doc/BRIEF.md
# Accumulating ALU with post-shifter

This block is the arithmetic core of a fixed-point audio signal processor. Each issued operation picks an A operand and a B operand and combines them in a sixteen-function ALU. A post-ALU shifter then scales, saturates or rotates the result, and the outcome is stored in a 32-bit accumulator. The A and B operands come from the accumulator, from either of two 16-bit ALU inputs placed in the upper half, or from a shared multiplier. The multiplier forms either a doubled product of two 16-bit inputs, or one input times a scaled copy of the accumulator.

Arithmetic codes drive carry and overflow. Zero, negative and exact flags are taken from the ALU result before the shifter acts on it. Every accepted operation also produces a 16-bit writeback word, which is the upper half of the new accumulator. A strobe marks that word one cycle after issue. Operand fetch, memory and program flow are handled around this block.

Top module: `acc_alu_shift`

## Requirements
- R1: While rst_n is low at a clock edge, the accumulator, all five flags and wb_data clear to zero and wb_valid goes low.
- R2: The accumulator, flags and wb_data change only at an edge where in_valid is high. wb_valid equals in_valid of the previous cycle. After an accepted operation, wb_data equals bits 31:16 of the new accumulator.
- R3: sel_a selects the A operand. 0 gives the accumulator, 1 gives {opnd_p,16'h0} and 2 gives {opnd_q,16'h0}. 3 gives the multiplier: when prod_sel is 1 it is the low 32 bits of 2*mul_x*mul_y, taken as signed values. When prod_sel is 0 it is mul_x times the result of the accumulator arithmetic-shifted right by 15 with bit 0 cleared.
- R4: sel_b selects the B operand with the same four code meanings and the same multiplier value as sel_a.
- R5: When alu_op is 3 or 5, B is {15'h0,C,16'h0}, where C is the stored carry flag. If in addition sel_a is 3 and prod_sel is 0, A is {mul_x,16'h0} when C is 1 and zero when C is 0.
- R6: alu_op gives the result Y as follows. 0 and 8 give A. 1 gives 0-B. 2 and 3 give A+B. 4 and 5 give A-B. 6 gives A+0x1000 and 7 gives A-0x1000. 9 gives ~A. 10 to 15 give AND, NAND, OR, NOR, XOR and XNOR of A and B.
- R7: Codes 1 to 7 set carry and overflow. Additions give the unsigned carry-out. Subtractions give carry as "no borrow", that is minuend >= subtrahend unsigned. Overflow is signed 32-bit overflow. All other codes clear both flags, except as stated in R11.
- R8: zero is set when Y[31:16] is all zero, negative is Y[31], and exact is set when Y[15:12] is all zero. All three are taken from Y before the shifter.
- R9: The shift code is {alu_op[3],shift_fld}. Codes 1 to 6 and 17 to 22 shift left by 1, 2, 3, 4, 5 and 8. Codes 9 to 15 shift right arithmetically, and codes 25 to 31 shift right logically, by 16, 8, 5, 4, 3, 2 and 1. Codes 0 and 16 leave Y unchanged.
- R10: Shift codes 7 and 23 act only when overflow is set. The result is then 0x7FFFF000 if negative is set and 0x80000000 if it is clear; otherwise Y is unchanged.
- R11: For shift codes 8 and 24, carry becomes Y[31]. The result is (Y<<1) masked to bits 31:17, with that carry in bit 16 and Y[15:12] kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue strobe for one operation |
| sel_a | input | 2 | A operand select |
| sel_b | input | 2 | B operand select |
| prod_sel | input | 1 | Multiplier mode: 1 = mul_x*mul_y*2 |
| alu_op | input | 4 | ALU function code |
| shift_fld | input | 4 | Shifter field, bits 3:0 of the shift code |
| mul_x | input | 16 | First multiplier input, signed |
| mul_y | input | 16 | Second multiplier input, signed |
| opnd_p | input | 16 | First ALU input |
| opnd_q | input | 16 | Second ALU input |
| acc | output | 32 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_x | output | 1 | Exact flag |
| wb_data | output | 16 | Writeback word |
| wb_valid | output | 1 | Writeback strobe |

## Verification
The bench targets the cases that are easy to get slightly wrong:
- Subtract carry has "no borrow" polarity. Getting it backwards flips the carry of every subtraction, including 0-0.
- The carry-in codes must replace both operands. A design that keeps the normal B would produce a plain add or subtract.
- Flags must be taken before the shifter. Sampling them afterwards changes zero and exact on every shifted result.
- Clipping must depend on overflow and on the pre-shift sign. Inverting that choice swaps the two saturation values.
- The rotate code must keep bits 15:12 and feed bit 31 into bit 16. Treating it as a plain left shift loses both.

Long random runs compare every cycle against a behavioural model. They also catch misordered shift amounts and a multiplier that uses the wrong sign extension or accumulator scaling.

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int OPW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [1:0]     sel_a,
  input  logic [1:0]     sel_b,
  input  logic           prod_sel,
  input  logic [3:0]     alu_op,
  input  logic [3:0]     shift_fld,
  input  logic [OPW-1:0] mul_x,
  input  logic [OPW-1:0] mul_y,
  input  logic [OPW-1:0] opnd_p,
  input  logic [OPW-1:0] opnd_q,
  output logic [2*OPW-1:0] acc,
  output logic           flag_z,
  output logic           flag_n,
  output logic           flag_c,
  output logic           flag_v,
  output logic           flag_x,
  output logic [OPW-1:0] wb_data,
  output logic           wb_valid
);
  localparam int AW = 2*OPW;
  localparam logic [AW-1:0] STEP = AW'(32'h1000);
  localparam logic [AW-1:0] SAT_POS = AW'(32'h7FFFF000);
  localparam logic [AW-1:0] SAT_NEG = AW'(32'h80000000);

  logic [AW-1:0] acc_q;
  logic z_q, n_q, c_q, v_q, x_q, wbv_q;
  logic [OPW-1:0] wb_q;

  logic signed [AW-1:0] mx_s, my_s, acc_scaled, prod;
  logic carry_op;
  logic [AW-1:0] a_op, b_op;

  assign mx_s = AW'($signed(mul_x));
  assign my_s = AW'($signed(mul_y));
  assign acc_scaled = ($signed(acc_q) >>> 15) & ~AW'(1);
  assign prod = prod_sel ? (mx_s * my_s) <<< 1 : mx_s * acc_scaled;
  assign carry_op = (alu_op == 4'd3) || (alu_op == 4'd5);

  always_comb begin
    case (sel_a)
      2'd0: a_op = acc_q;
      2'd1: a_op = {opnd_p, {OPW{1'b0}}};
      2'd2: a_op = {opnd_q, {OPW{1'b0}}};
      default: begin
        if (carry_op && !prod_sel) a_op = c_q ? {mul_x, {OPW{1'b0}}} : '0;
        else a_op = prod;
      end
    endcase
  end

  always_comb begin
    if (carry_op) b_op = AW'({c_q, {OPW{1'b0}}});
    else begin
      case (sel_b)
        2'd0: b_op = acc_q;
        2'd1: b_op = {opnd_p, {OPW{1'b0}}};
        2'd2: b_op = {opnd_q, {OPW{1'b0}}};
        default: b_op = prod;
      endcase
    end
  end

  logic [AW-1:0] ar_l, ar_r, ar_y, y;
  logic ar_sub, is_arith, c_alu, v_alu;

  always_comb begin
    ar_l = a_op;
    ar_r = b_op;
    ar_sub = 1'b0;
    is_arith = 1'b1;
    case (alu_op)
      4'd1: begin ar_l = '0; ar_sub = 1'b1; end
      4'd2, 4'd3: ;
      4'd4, 4'd5: ar_sub = 1'b1;
      4'd6: ar_r = STEP;
      4'd7: begin ar_r = STEP; ar_sub = 1'b1; end
      default: is_arith = 1'b0;
    endcase
  end

  assign ar_y = ar_sub ? ar_l - ar_r : ar_l + ar_r;

  always_comb begin
    c_alu = 1'b0;
    v_alu = 1'b0;
    if (is_arith) begin
      if (ar_sub) begin
        c_alu = (ar_l[AW-1] & ~ar_r[AW-1]) | (ar_l[AW-1] & ~ar_y[AW-1]) | (~ar_r[AW-1] & ~ar_y[AW-1]);
        v_alu = (ar_l[AW-1] != ar_r[AW-1]) && (ar_y[AW-1] != ar_l[AW-1]);
      end else begin
        c_alu = (ar_l[AW-1] & ar_r[AW-1]) | (ar_l[AW-1] & ~ar_y[AW-1]) | (ar_r[AW-1] & ~ar_y[AW-1]);
        v_alu = (ar_l[AW-1] == ar_r[AW-1]) && (ar_y[AW-1] != ar_l[AW-1]);
      end
    end
  end

  always_comb begin
    case (alu_op)
      4'd0, 4'd8: y = a_op;
      4'd9:  y = ~a_op;
      4'd10: y = a_op & b_op;
      4'd11: y = ~(a_op & b_op);
      4'd12: y = a_op | b_op;
      4'd13: y = ~(a_op | b_op);
      4'd14: y = a_op ^ b_op;
      4'd15: y = ~(a_op ^ b_op);
      default: y = ar_y;
    endcase
  end

  logic z_pre, n_pre, x_pre;
  assign z_pre = (y[AW-1:OPW] == '0);
  assign n_pre = y[AW-1];
  assign x_pre = (y[OPW-1:OPW-4] == '0);

  logic [4:0] sc;
  logic [AW-1:0] sh;
  logic c_next;
  assign sc = {alu_op[3], shift_fld};

  always_comb begin
    sh = y;
    c_next = c_alu;
    case (sc)
      5'd1,  5'd17: sh = y << 1;
      5'd2,  5'd18: sh = y << 2;
      5'd3,  5'd19: sh = y << 3;
      5'd4,  5'd20: sh = y << 4;
      5'd5,  5'd21: sh = y << 5;
      5'd6,  5'd22: sh = y << 8;
      5'd9:  sh = $signed(y) >>> 16;
      5'd10: sh = $signed(y) >>> 8;
      5'd11: sh = $signed(y) >>> 5;
      5'd12: sh = $signed(y) >>> 4;
      5'd13: sh = $signed(y) >>> 3;
      5'd14: sh = $signed(y) >>> 2;
      5'd15: sh = $signed(y) >>> 1;
      5'd25: sh = y >> 16;
      5'd26: sh = y >> 8;
      5'd27: sh = y >> 5;
      5'd28: sh = y >> 4;
      5'd29: sh = y >> 3;
      5'd30: sh = y >> 2;
      5'd31: sh = y >> 1;
      5'd7, 5'd23: if (v_alu) sh = n_pre ? SAT_POS : SAT_NEG;
      5'd8, 5'd24: begin
        c_next = y[AW-1];
        sh = {y[AW-2:OPW], y[AW-1], y[OPW-1:OPW-4], {(OPW-4){1'b0}}};
      end
      default: sh = y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      {z_q, n_q, c_q, v_q, x_q} <= '0;
      wb_q  <= '0;
      wbv_q <= 1'b0;
    end else begin
      wbv_q <= in_valid;
      if (in_valid) begin
        acc_q <= sh;
        wb_q  <= sh[AW-1:OPW];
        z_q <= z_pre;
        n_q <= n_pre;
        c_q <= c_next;
        v_q <= v_alu;
        x_q <= x_pre;
      end
    end
  end

  assign acc = acc_q;
  assign flag_z = z_q;
  assign flag_n = n_q;
  assign flag_c = c_q;
  assign flag_v = v_q;
  assign flag_x = x_q;
  assign wb_data = wb_q;
  assign wb_valid = wbv_q;
endmodule

module acc_alu_shift_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  alu_op,
  input logic [3:0]  shift_fld,
  input logic [31:0] acc,
  input logic        flag_z,
  input logic        flag_n,
  input logic        flag_c,
  input logic        flag_v,
  input logic        flag_x,
  input logic [15:0] wb_data,
  input logic        wb_valid
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (acc == 32'h0 && !wb_valid && !flag_c && !flag_v && wb_data == 16'h0));

  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> wb_valid);

  a_r2_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !wb_valid);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc) && $stable({flag_z, flag_n, flag_c, flag_v, flag_x}) && $stable(wb_data)));

  a_r2_wb_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_data == acc[31:16]);

  a_r7_logic_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (alu_op == 4'd0 || alu_op >= 4'd8)) |=> !flag_v);

  a_r7_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (alu_op == 4'd0 || alu_op >= 4'd8) && shift_fld != 4'd8) |=> !flag_c);
endmodule

bind acc_alu_shift acc_alu_shift_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .alu_op(alu_op), .shift_fld(shift_fld),
  .acc(acc), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
  .flag_x(flag_x), .wb_data(wb_data), .wb_valid(wb_valid)
);

// File: tb/acc_alu_shift_tb.sv
`timescale 1ns/1ps
module acc_alu_shift_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] sel_a = '0, sel_b = '0;
  logic prod_sel = 1'b0;
  logic [3:0] alu_op = '0, shift_fld = '0;
  logic [15:0] mul_x = '0, mul_y = '0, opnd_p = '0, opnd_q = '0;
  logic [31:0] acc;
  logic flag_z, flag_n, flag_c, flag_v, flag_x, wb_valid;
  logic [15:0] wb_data;

  always #4 clk = ~clk;

  acc_alu_shift dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_a(sel_a), .sel_b(sel_b),
    .prod_sel(prod_sel), .alu_op(alu_op), .shift_fld(shift_fld), .mul_x(mul_x),
    .mul_y(mul_y), .opnd_p(opnd_p), .opnd_q(opnd_q), .acc(acc), .flag_z(flag_z),
    .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v), .flag_x(flag_x),
    .wb_data(wb_data), .wb_valid(wb_valid)
  );

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  bit [31:0] e_acc = 0;
  bit e_z = 0, e_n = 0, e_c = 0, e_v = 0, e_x = 0, e_wbv = 0;
  bit [15:0] e_wb = 0;

  function automatic bit sovf(longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  task automatic model(input bit [1:0] ma, input bit [1:0] mb, input bit ps,
                       input bit [3:0] op, input bit [3:0] sf,
                       input bit [15:0] x, input bit [15:0] yy,
                       input bit [15:0] p, input bit [15:0] q);
    longint sa, pv, t, sl, sr;
    bit [31:0] pr, a, b, r, res;
    bit [32:0] w;
    bit c, v, n0, ci;
    int sc, k, amt;
    sa = longint'($signed(e_acc));
    if (ps) pv = longint'($signed(x)) * longint'($signed(yy)) * 2;
    else begin
      t = sa >>> 15;
      t = t - (t & 1);
      pv = longint'($signed(x)) * t;
    end
    pr = pv[31:0];
    ci = (op == 3) || (op == 5);
    case (ma)
      0: a = e_acc;
      1: a = {p, 16'h0};
      2: a = {q, 16'h0};
      default: a = (ci && !ps) ? (e_c ? {x, 16'h0} : 32'h0) : pr;
    endcase
    case (mb)
      0: b = e_acc;
      1: b = {p, 16'h0};
      2: b = {q, 16'h0};
      default: b = pr;
    endcase
    if (ci) b = e_c ? 32'h0001_0000 : 32'h0;
    c = 0; v = 0;
    case (op)
      1: begin r = 32'h0 - b; c = (b == 0); v = sovf(-longint'($signed(b))); end
      2, 3: begin w = {1'b0, a} + {1'b0, b}; r = w[31:0]; c = w[32];
                  v = sovf(longint'($signed(a)) + longint'($signed(b))); end
      4, 5: begin r = a - b; c = (a >= b); v = sovf(longint'($signed(a)) - longint'($signed(b))); end
      6: begin w = {1'b0, a} + 33'h1000; r = w[31:0]; c = w[32];
               v = sovf(longint'($signed(a)) + 4096); end
      7: begin r = a - 32'h1000; c = (a >= 32'h1000); v = sovf(longint'($signed(a)) - 4096); end
      9:  r = ~a;
      10: r = a & b;
      11: r = ~(a & b);
      12: r = a | b;
      13: r = ~(a | b);
      14: r = a ^ b;
      15: r = ~(a ^ b);
      default: r = a;
    endcase
    n0 = r[31];
    e_z = (r[31:16] == 0);
    e_n = n0;
    e_x = (r[15:12] == 0);
    sc = {op[3], sf};
    k = sc % 16;
    res = r;
    if (k >= 1 && k <= 6) begin
      amt = (k == 6) ? 8 : k;
      res = r << amt;
    end else if (k >= 9) begin
      amt = (k == 9) ? 16 : (k == 10) ? 8 : 16 - k;
      if (sc < 16) res = 32'($signed(r) >>> amt);
      else res = r >> amt;
    end else if (k == 7) begin
      if (v) res = n0 ? 32'h7FFF_F000 : 32'h8000_0000;
    end else if (k == 8) begin
      c = r[31];
      res = (r << 1) & 32'hFFFE_0000;
      res = res | (c ? 32'h0001_0000 : 32'h0) | (r & 32'h0000_F000);
    end
    e_acc = res;
    e_c = c;
    e_v = v;
    e_wb = res[31:16];
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (acc !== e_acc || wb_data !== e_wb || wb_valid !== e_wbv ||
        {flag_z, flag_n, flag_c, flag_v, flag_x} !== {e_z, e_n, e_c, e_v, e_x}) begin
      misses++;
      $display("FAIL %s acc=%h wb=%h wbv=%b znvcx=%b%b%b%b%b expected acc=%h wb=%h wbv=%b znvcx=%b%b%b%b%b",
               tag, acc, wb_data, wb_valid, flag_z, flag_n, flag_v, flag_c, flag_x,
               e_acc, e_wb, e_wbv, e_z, e_n, e_v, e_c, e_x);
    end
  endtask

  task automatic step(input bit vld, input bit [1:0] ma, input bit [1:0] mb, input bit ps,
                      input bit [3:0] op, input bit [3:0] sf,
                      input bit [15:0] x, input bit [15:0] yy,
                      input bit [15:0] p, input bit [15:0] q, input string tag);
    in_valid = vld; sel_a = ma; sel_b = mb; prod_sel = ps; alu_op = op; shift_fld = sf;
    mul_x = x; mul_y = yy; opnd_p = p; opnd_q = q;
    if (vld) model(ma, mb, ps, op, sf, x, yy, p, q);
    e_wbv = vld;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic load_hi(input bit [15:0] h);
    step(1, 1, 0, 0, 0, 0, 0, 0, h, 0, "R3 load");
  endtask

  task automatic lit(input bit [31:0] want, input string tag);
    vectors++;
    if (acc !== want) begin
      misses++;
      $display("FAIL %s acc=%h expected %h", tag, acc, want);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1; opnd_p = 16'hFFFF; sel_a = 2'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e_wbv = 0;
    compare("R1 reset state");
    rst_n = 1'b1;

    load_hi(16'h1234);
    step(0, 1, 1, 1, 2, 3, 16'h7, 16'h9, 16'hAAAA, 16'h5555, "R2 idle hold 1");
    step(0, 3, 3, 0, 15, 8, 16'h1, 16'h2, 16'h3, 16'h4, "R2 idle hold 2");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 pass accumulator");

    step(1, 2, 0, 0, 0, 0, 0, 0, 0, 16'hBEEF, "R3 sel_a=2");
    step(1, 3, 0, 1, 0, 0, 16'h0003, 16'hFFFE, 0, 0, "R3 doubled product");
    lit(32'hFFFF_FFF4, "R3 3*-2*2");
    load_hi(16'h0005);
    step(1, 3, 0, 0, 0, 0, 16'h0007, 0, 0, 0, "R3 scaled accumulator product");
    lit(32'd70, "R3 7*10");
    load_hi(16'hFFFB);
    step(1, 3, 0, 0, 0, 0, 16'h0101, 0, 0, 0, "R3 negative scaled product");

    load_hi(16'h0100);
    for (int mb = 0; mb < 4; mb++)
      step(1, 1, 2'(mb), 1, 2, 0, 16'h0040, 16'h0003, 16'h0020, 16'h0010, "R4 sel_b codes");

    load_hi(16'hFFFF);
    step(1, 0, 1, 0, 2, 0, 0, 0, 16'h0001, 0, "R7 add carry out");
    step(1, 1, 2, 0, 3, 0, 0, 0, 16'h0100, 16'h7777, "R5 add with carry");
    lit(32'h0101_0000, "R5 0x100 + carry");
    step(1, 3, 1, 0, 5, 0, 16'h0222, 0, 16'h3333, 0, "R5 carry-dependent A");
    load_hi(16'h0001);
    step(1, 1, 0, 0, 4, 0, 0, 0, 16'h0000, 0, "R7 borrow 0-1");
    step(1, 3, 1, 0, 5, 0, 16'h0222, 0, 16'h3333, 0, "R5 carry clear gives zero A");

    for (int op = 0; op < 16; op++) begin
      load_hi(16'h0F0F);
      step(1, 1, 2, 0, 4'(op), 0, 0, 0, 16'h1234, 16'h00F0, "R6 function table");
    end

    step(1, 1, 1, 0, 1, 0, 0, 0, 16'h0000, 0, "R7 zero minus zero carry set");
    step(1, 1, 1, 0, 1, 0, 0, 0, 16'h8000, 0, "R7 negate minimum overflows");
    step(1, 1, 2, 0, 2, 0, 0, 0, 16'h7FFF, 16'h7FFF, "R7 signed add overflow");
    step(1, 1, 2, 0, 4, 0, 0, 0, 16'h8000, 16'h0001, "R7 signed sub overflow");
    load_hi(16'h7FFF);
    step(1, 0, 0, 0, 6, 0, 0, 0, 0, 0, "R8 step up sets nonexact");
    step(1, 0, 0, 0, 7, 0, 0, 0, 0, 0, "R8 step down exact again");
    load_hi(16'h0000);
    step(1, 0, 0, 0, 7, 0, 0, 0, 0, 0, "R8 negative with step");
    load_hi(16'h0001);
    step(1, 0, 0, 0, 0, 9, 0, 0, 0, 0, "R8 flags before shift");

    for (int op8 = 0; op8 < 2; op8++)
      for (int sf = 0; sf < 16; sf++) begin
        load_hi(16'hC3A5);
        step(1, 0, 0, 0, op8 ? 4'd8 : 4'd0, 4'(sf), 0, 0, 0, 0, "R9 shift code sweep");
      end

    step(1, 1, 2, 0, 2, 7, 0, 0, 16'h7FFF, 16'h0001, "R10 clip positive overflow");
    lit(32'h7FFF_F000, "R10 clip to max");
    step(1, 1, 2, 0, 2, 7, 0, 0, 16'h8000, 16'h8000, "R10 clip negative overflow");
    lit(32'h8000_0000, "R10 clip to min");
    step(1, 1, 2, 0, 2, 7, 0, 0, 16'h1000, 16'h0001, "R10 no overflow no clip");

    load_hi(16'hC000);
    step(1, 0, 0, 0, 6, 8, 0, 0, 0, 0, "R11 rotate through carry");
    lit(32'h8001_1000, "R11 rotate value");
    step(1, 0, 0, 0, 14, 8, 0, 0, 0, 0, "R11 rotate code 24");

    for (int i = 0; i < 3000; i++)
      step(($urandom % 5) != 0, 2'($urandom), 2'($urandom), 1'($urandom), 4'($urandom),
           4'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
           "R2-random mix");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule